// File: doc/BRIEF.md
# General-Call Software Reset Detector

This block sits on the slave side of an I2C bus and listens for one specific transaction: the general-call software reset. It brings SCL and SDA into the system clock domain, finds START and STOP conditions, assembles each byte as it arrives and answers the master by pulling SDA low through an open-drain enable. It ignores ordinary device traffic and only answers the reserved all-zero write address and the single reset command byte that follows it.

When the master ends a correct sequence (START, address byte 00h, command byte 06h, STOP), the block sends a one-cycle reset pulse to the registers and state machine of its host device. A read-flavoured general call, a wrong command, an extra byte or a repeated START before the STOP cancels the pending reset. An active-low hardware reset pin holds the whole block in its idle state for as long as it is low.

Top module: `swrst_watch`

## Requirements
- R1: While `hw_rst_n` is low, `sda_oe` and `swrst_pulse` stay 0, and a sequence in progress when the pin falls is discarded, so a later STOP produces no pulse.
- R2: An address byte of 00h (seven zero address bits with R/W bit, bit 0, equal to 0) following a START is acknowledged: `sda_oe` is 1 while SCL is high during the ninth clock of that byte.
- R3: Any other address byte, including 01h (general call with R/W = 1), is not acknowledged, and none of the bytes after it in the same transfer are acknowledged.
- R4: After an acknowledged 00h address, a first data byte equal to 06h is acknowledged.
- R5: After an acknowledged 00h address, a first data byte other than 06h is not acknowledged and no reset pulse follows.
- R6: Every byte after the acknowledged 06h is left unacknowledged, and its arrival cancels the pending reset.
- R7: `swrst_pulse` is high for exactly one system clock cycle, and only once, after the STOP that ends a START, 00h, 06h sequence; it never rises otherwise.
- R8: A repeated START arriving after the 06h byte and before the STOP cancels the pending reset.
- R9: A START seen partway through a byte restarts bit counting, so a complete valid sequence after it still produces the reset pulse.
- R10: The acknowledge is only asserted while SCL is low, after the eighth clock's falling edge, and `sda_oe` returns to 0 after the ninth clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Active-low hardware reset, asynchronous assert |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (open-drain acknowledge) |
| swrst_pulse | output | 1 | One-cycle reset request to the host device |

## Verification
A wrong bit counter shows up at the ports within one byte: the acknowledge lands on the wrong SCL clock, is missing during the ninth clock, or is still held after it, and the bench samples `sda_oe` in the middle of every ninth clock and again after it. A wrong decision state shows up at the latest on the next STOP, as a missing, extra or widened `swrst_pulse`, which the bench counts per transaction. State that survives a hardware reset or a repeated START appears as a pulse on a STOP that should have been silent.

// File: rtl/gcrst_pkg.sv
package gcrst_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] GC_ADDR_BYTE = 8'h00;
    localparam logic [BYTE_W-1:0] GC_RESET_CMD = 8'h06;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_ARMED,
        PH_SKIP
    } gc_phase_e;

endpackage

// File: rtl/gcrst_bus_sync.sv
module gcrst_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_s     = q.scl_pipe[STAGES-1];
    assign sda_s     = q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/gcrst_byte_rx.sv
module gcrst_byte_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              clr,
    input  logic              ack_req,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              oe;
    } rx_t;

    rx_t q, d;

    assign byte_done = q.active & scl_rise & (q.cnt == LAST_BIT);
    assign byte_val  = {q.shreg[BYTE_W-2:0], sda_s};
    assign sda_oe    = q.oe;

    always_comb begin
        d = q;
        if (start_det) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.oe     = 1'b0;
        end else if (stop_det || clr) begin
            d.active = 1'b0;
            d.cnt    = '0;
            d.oe     = 1'b0;
        end else if (q.active) begin
            if (scl_rise) begin
                if (q.cnt < ACK_SLOT) begin
                    d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                    d.cnt   = q.cnt + CNT_W'(1);
                end else if (q.cnt == ACK_SLOT) begin
                    d.cnt = ACK_DONE;
                end
            end else if (scl_fall) begin
                if (q.cnt == ACK_SLOT) begin
                    d.oe = ack_req;
                end else if (q.cnt == ACK_DONE) begin
                    d.oe  = 1'b0;
                    d.cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/gcrst_ctrl.sv
module gcrst_ctrl
    import gcrst_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          byte_done,
    input  logic [BW-1:0] byte_val,
    output logic          ack_req,
    output logic          swrst_pulse
);

    typedef struct packed {
        gc_phase_e phase;
        logic      ack;
        logic      pulse;
    } ctrl_t;

    ctrl_t q, d;

    assign ack_req     = q.ack;
    assign swrst_pulse = q.pulse;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (start_det) begin
            d.phase = PH_ADDR;
            d.ack   = 1'b0;
        end else if (stop_det) begin
            d.pulse = (q.phase == PH_ARMED);
            d.phase = PH_IDLE;
            d.ack   = 1'b0;
        end else if (q.pulse) begin
            d.phase = PH_IDLE;
            d.ack   = 1'b0;
        end else if (byte_done) begin
            case (q.phase)
                PH_ADDR: begin
                    if (byte_val == BW'(GC_ADDR_BYTE)) begin
                        d.ack   = 1'b1;
                        d.phase = PH_CMD;
                    end else begin
                        d.ack   = 1'b0;
                        d.phase = PH_SKIP;
                    end
                end
                PH_CMD: begin
                    if (byte_val == BW'(GC_RESET_CMD)) begin
                        d.ack   = 1'b1;
                        d.phase = PH_ARMED;
                    end else begin
                        d.ack   = 1'b0;
                        d.phase = PH_SKIP;
                    end
                end
                PH_ARMED: begin
                    d.ack   = 1'b0;
                    d.phase = PH_SKIP;
                end
                default: begin
                    d.ack = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.ack   <= 1'b0;
            q.pulse <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/swrst_watch.sv
module swrst_watch
    import gcrst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic swrst_pulse
);

    logic              scl_s_w;
    logic              sda_s_w;
    logic              scl_rise_w;
    logic              scl_fall_w;
    logic              start_w;
    logic              stop_w;
    logic              byte_done_w;
    logic [BYTE_W-1:0] byte_val_w;
    logic              ack_req_w;

    gcrst_bus_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (hw_rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s_w),
        .sda_s    (sda_s_w),
        .scl_rise (scl_rise_w),
        .scl_fall (scl_fall_w),
        .start_det(start_w),
        .stop_det (stop_w)
    );

    gcrst_byte_rx #(
        .BYTE_W(BYTE_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (hw_rst_n),
        .scl_rise (scl_rise_w),
        .scl_fall (scl_fall_w),
        .sda_s    (sda_s_w),
        .start_det(start_w),
        .stop_det (stop_w),
        .clr      (swrst_pulse),
        .ack_req  (ack_req_w),
        .byte_done(byte_done_w),
        .byte_val (byte_val_w),
        .sda_oe   (sda_oe)
    );

    gcrst_ctrl #(
        .BW(BYTE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (hw_rst_n),
        .start_det  (start_w),
        .stop_det   (stop_w),
        .byte_done  (byte_done_w),
        .byte_val   (byte_val_w),
        .ack_req    (ack_req_w),
        .swrst_pulse(swrst_pulse)
    );

endmodule

// File: rtl/swrst_watch_chk.sv
module swrst_watch_chk (
    input logic clk,
    input logic hw_rst_n,
    input logic sda_oe,
    input logic swrst_pulse,
    input logic stop_w,
    input logic scl_s_w
);

    // R1
    always @(posedge clk) begin
        if (!hw_rst_n) begin
            held_in_reset_chk: assert (!sda_oe && !swrst_pulse);
        end
    end

    // R7
    pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        swrst_pulse |=> !swrst_pulse);

    // R7
    pulse_after_stop_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        swrst_pulse |-> $past(stop_w));

    // R10
    ack_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(sda_oe) |-> !scl_s_w);

endmodule

bind swrst_watch swrst_watch_chk u_chk (
    .clk        (clk),
    .hw_rst_n   (hw_rst_n),
    .sda_oe     (sda_oe),
    .swrst_pulse(swrst_pulse),
    .stop_w     (stop_w),
    .scl_s_w    (scl_s_w)
);

// File: tb/tb_swrst_watch.sv
module tb_swrst_watch;

    localparam int H = 20;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_i;
    logic sda_oe;
    logic swrst_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int pulse_cnt = 0;
    int wide_cnt = 0;
    int rel_err = 0;
    logic prev_pulse = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_i = sda_m & ~sda_oe;

    swrst_watch dut (
        .clk        (clk),
        .hw_rst_n   (hw_rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_i),
        .sda_oe     (sda_oe),
        .swrst_pulse(swrst_pulse)
    );

    always @(posedge clk) begin
        if (swrst_pulse) pulse_cnt <= pulse_cnt + 1;
        if (swrst_pulse && prev_pulse) wide_cnt <= wide_cnt + 1;
        prev_pulse <= swrst_pulse;
    end

    // addr[20:13] cmd[12:5] extra[4] exp_addr_ack[3] exp_cmd_ack[2] exp_extra_ack[1] exp_pulse[0]
    localparam logic [20:0] VEC [0:6] = '{
        {8'h00, 8'h06, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R2 R4 R7 valid
        {8'h01, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 read general call
        {8'h00, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 wrong command
        {8'h00, 8'h06, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 extra byte
        {8'h40, 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 other address
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 zero command
        {8'h00, 8'h86, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}   // R5 high bit set
    };

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_h(H);
        scl_m = 1'b1; wait_h(H);
        sda_m = 1'b0; wait_h(H);
        scl_m = 1'b0; wait_h(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_h(H);
        scl_m = 1'b1; wait_h(H);
        sda_m = 1'b1; wait_h(2 * H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; wait_h(H);
            scl_m = 1'b1; wait_h(H);
            scl_m = 1'b0; wait_h(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        send_bits(b, 8);
        sda_m = 1'b1; wait_h(H);
        scl_m = 1'b1; wait_h(H / 2);
        ackd = sda_oe;
        wait_h(H / 2);
        scl_m = 1'b0; wait_h(H);
        if (sda_oe) rel_err++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2;
        int p0;

        // R1 reset state
        wait_h(10);
        chk(sda_oe == 1'b0, "R1 oe in reset", int'(sda_oe), 0);
        chk(swrst_pulse == 1'b0, "R1 pulse in reset", int'(swrst_pulse), 0);
        hw_rst_n = 1'b1;
        wait_h(10);

        for (int v = 0; v < 7; v++) begin
            p0 = pulse_cnt;
            rel_err = 0;
            a2 = 1'b0;
            bus_start();
            send_byte(VEC[v][20:13], a0);
            send_byte(VEC[v][12:5], a1);
            if (VEC[v][4]) send_byte(8'h06, a2);
            bus_stop();
            wait_h(10);
            chk(a0 == VEC[v][3], $sformatf("R2/R3 addr ack vec %0d", v), int'(a0), int'(VEC[v][3]));
            chk(a1 == VEC[v][2], $sformatf("R4/R5 cmd ack vec %0d", v), int'(a1), int'(VEC[v][2]));
            if (VEC[v][4])
                chk(a2 == VEC[v][1], $sformatf("R6 extra ack vec %0d", v), int'(a2), int'(VEC[v][1]));
            chk(pulse_cnt - p0 == int'(VEC[v][0]), $sformatf("R7 pulse count vec %0d", v),
                pulse_cnt - p0, int'(VEC[v][0]));
            chk(rel_err == 0, $sformatf("R10 ack release vec %0d", v), rel_err, 0);
        end

        // R8 repeated START cancels pending reset
        p0 = pulse_cnt;
        bus_start();
        send_byte(8'h00, a0);
        send_byte(8'h06, a1);
        bus_start();
        bus_stop();
        wait_h(10);
        chk(a1 == 1'b1, "R8 cmd acked", int'(a1), 1);
        chk(pulse_cnt == p0, "R8 no pulse", pulse_cnt - p0, 0);

        // R9 START partway through a byte
        p0 = pulse_cnt;
        bus_start();
        send_bits(8'hA5, 4);
        bus_start();
        send_byte(8'h00, a0);
        send_byte(8'h06, a1);
        bus_stop();
        wait_h(10);
        chk(a0 == 1'b1 && a1 == 1'b1, "R9 acks after restart", int'({a0, a1}), 3);
        chk(pulse_cnt - p0 == 1, "R9 pulse after restart", pulse_cnt - p0, 1);

        // R1 hardware reset mid-sequence discards it
        p0 = pulse_cnt;
        bus_start();
        send_byte(8'h00, a0);
        send_byte(8'h06, a1);
        hw_rst_n = 1'b0;
        wait_h(10);
        chk(sda_oe == 1'b0, "R1 oe held low", int'(sda_oe), 0);
        hw_rst_n = 1'b1;
        wait_h(10);
        bus_stop();
        wait_h(10);
        chk(pulse_cnt == p0, "R1 sequence discarded", pulse_cnt - p0, 0);

        // R7 pulse width over the whole run
        chk(wide_cnt == 0, "R7 pulse one cycle", wide_cnt, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule